// File: doc/BRIEF.md
# Pseudorandom Upset Injector for State Registers

This block emulates radiation-induced bit flips in the state registers of several identical finite state machines running side by side. A down-to-earth rate counter spaces the injections, and a 16-bit maximal-length shift register with linear feedback picks which bit (or pair of bits) gets hit. Every injection appears as a one-cycle strobe together with a 16-bit mask. The same mask goes to every machine under test, so all of them are disturbed at the same time and their outputs can be compared with an undisturbed copy.

The injection spacing is programmable and can be set to a value that shares no factor with the period of the stimulus fed to the machines under test (for example 199 cycles), so the upsets drift across every phase of the pattern. Writing a spacing of zero stops injection entirely. One mode input picks one-bit or two-bit masks. A second mode input enables the built-in synchronous path: a state word passed through the block comes back with the masked bits inverted for exactly the strobe cycle.

Top module: `fault_injector`

## Requirements
- R1: While reset is held and on the first cycle after it, `faultValid` is 0 and `faultField` is all zeros.
- R2: When `rateLimit` is 0, no strobe is produced and `faultField` stays zero for as long as it stays 0.
- R3: With `rateLimit` = N (N ≥ 1) and held steady, consecutive strobes are exactly N clock cycles apart. N = 1 gives a strobe every cycle.
- R4: With `doubleMode` = 0, each strobe carries exactly one set bit, at the index given by bits [3:0] of the generator state.
- R5: With `doubleMode` = 1, each strobe carries exactly two set bits. The first is at index state[3:0]. The second is at index state[7:4], or, if that equals the first, at (state[3:0] + 1) mod 16.
- R6: The generator is a left-shifting Fibonacci register. The new bit 0 is the XOR of state bits 15, 14, 12 and 3 (taps 16,15,13,4). Reset seeds it with 16'hACE1. It steps exactly once per strobe, and the mask of a strobe uses the state before that step.
- R7: `faultField` is all zeros on every cycle on which `faultValid` is 0.
- R8: With `syncEnable` = 1, `targetOut` equals `targetIn` XOR `faultField`. With `syncEnable` = 0, `targetOut` equals `targetIn`. The inversion therefore lasts one cycle per strobe.
- R9: The generator state is never all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rateLimit | input | 16 | Cycles between injections; 0 disables injection |
| doubleMode | input | 1 | 0: one bit per mask, 1: two bits per mask |
| syncEnable | input | 1 | Apply the mask to `targetIn` to form `targetOut` |
| targetIn | input | 16 | State word to be disturbed |
| faultField | output | 16 | Injection mask, nonzero only on the strobe cycle |
| faultValid | output | 1 | One-cycle injection strobe |
| targetOut | output | 16 | State word after synchronous injection |

## Verification
The first pattern uses a spacing of five with single masks and the synchronous path on. It separates a correct index decode and one-cycle inversion from a mask that leaks into idle cycles. The second uses a spacing of one with double masks, which exposes counter off-by-one faults and a generator that steps at the wrong time. The third uses a long spacing of 199 with the synchronous path off, to show pass-through and long-interval timing. The fourth runs many back-to-back double masks at a spacing of two, which hits cases where both index slices collide and tells the bump-by-one rule apart from a dropped second bit. Quiet windows with a zero spacing before and after the runs show that no stray strobe appears.

// File: rtl/fi_pkg.sv
package fi_pkg;
  // Strobes the rate control hands to the mask datapath
  typedef struct packed {
    logic fire;   // take one injection on this edge
    logic quiet;  // injection disabled (zero spacing)
  } fiCtrl_t;
endpackage

// File: rtl/fi_rate_ctrl.sv
module fi_rate_ctrl
  import fi_pkg::*;
#(
  parameter int RATE_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [RATE_W-1:0] rateLimit,
  output fiCtrl_t           ctrl
);
  logic [RATE_W-1:0] tickCount;
  logic [RATE_W-1:0] lastTick;

  assign lastTick   = rateLimit - RATE_W'(1);
  assign ctrl.quiet = (rateLimit == '0);
  assign ctrl.fire  = !ctrl.quiet && (tickCount >= lastTick);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tickCount <= '0;
    end else if (ctrl.quiet || ctrl.fire) begin
      tickCount <= '0;
    end else begin
      tickCount <= tickCount + RATE_W'(1);
    end
  end

  AST_STROBE_SPACING: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.fire && rateLimit > RATE_W'(1)) |=> (!ctrl.fire || !$stable(rateLimit))); // R3
endmodule

// File: rtl/fi_mask_path.sv
module fi_mask_path
  import fi_pkg::*;
#(
  parameter int              FIELD_W = 16,
  parameter int              LFSR_W  = 16,
  parameter logic [LFSR_W-1:0] SEED  = 16'hACE1,
  parameter logic [LFSR_W-1:0] TAPS  = 16'hD008
) (
  input  logic               clk,
  input  logic               rstN,
  input  fiCtrl_t            ctrl,
  input  logic               doubleMode,
  output logic [FIELD_W-1:0] faultField,
  output logic               faultValid
);
  localparam int IDX_W = $clog2(FIELD_W);

  logic [LFSR_W-1:0]  lfsrState;
  logic [LFSR_W-1:0]  lfsrNext;
  logic [IDX_W-1:0]   idxFirst;
  logic [IDX_W-1:0]   idxSecondRaw;
  logic [IDX_W-1:0]   idxSecond;
  logic [FIELD_W-1:0] maskNext;

  assign lfsrNext     = {lfsrState[LFSR_W-2:0], ^(lfsrState & TAPS)};
  assign idxFirst     = lfsrState[IDX_W-1:0];
  assign idxSecondRaw = lfsrState[2*IDX_W-1:IDX_W];
  assign idxSecond    = (idxSecondRaw == idxFirst) ? idxFirst + IDX_W'(1) : idxSecondRaw;

  for (genvar g = 0; g < FIELD_W; g++) begin : gMaskBit
    assign maskNext[g] = (idxFirst == IDX_W'(g)) || (doubleMode && (idxSecond == IDX_W'(g)));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lfsrState  <= SEED;
      faultField <= '0;
      faultValid <= 1'b0;
    end else begin
      faultValid <= ctrl.fire;
      faultField <= ctrl.fire ? maskNext : '0;
      if (ctrl.fire) lfsrState <= lfsrNext;
    end
  end

  AST_SINGLE_WEIGHT: assert property (@(posedge clk) disable iff (!rstN)
    (faultValid && !$past(doubleMode)) |-> ($countones(faultField) == 1)); // R4
  AST_DOUBLE_WEIGHT: assert property (@(posedge clk) disable iff (!rstN)
    (faultValid && $past(doubleMode)) |-> ($countones(faultField) == 2)); // R5
  AST_FIELD_OFF_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !faultValid |-> (faultField == '0)); // R7
  AST_LFSR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !faultValid |-> $stable(lfsrState)); // R6
  AST_LFSR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    faultValid |-> (lfsrState != $past(lfsrState))); // R6
  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    lfsrState != '0); // R9
endmodule

// File: rtl/fault_injector.sv
module fault_injector
  import fi_pkg::*;
#(
  parameter int RATE_W  = 16,
  parameter int FIELD_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [RATE_W-1:0]  rateLimit,
  input  logic               doubleMode,
  input  logic               syncEnable,
  input  logic [FIELD_W-1:0] targetIn,
  output logic [FIELD_W-1:0] faultField,
  output logic               faultValid,
  output logic [FIELD_W-1:0] targetOut
);
  fiCtrl_t ctrlBus;

  fi_rate_ctrl #(.RATE_W(RATE_W)) uRate (
    .clk       (clk),
    .rstN      (rstN),
    .rateLimit (rateLimit),
    .ctrl      (ctrlBus)
  );

  fi_mask_path #(.FIELD_W(FIELD_W), .LFSR_W(16)) uMask (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrlBus),
    .doubleMode (doubleMode),
    .faultField (faultField),
    .faultValid (faultValid)
  );

  assign targetOut = syncEnable ? (targetIn ^ faultField) : targetIn;

  AST_QUIET_AT_ZERO_RATE: assert property (@(posedge clk) disable iff (!rstN)
    (rateLimit == '0 && $past(rateLimit) == '0) |-> !faultValid); // R2
  AST_TARGET_UNTOUCHED_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !faultValid |-> (targetOut == targetIn)); // R8
endmodule

// File: tb/sim_fault_injector.sv
module sim_fault_injector;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] rateLimit = '0;
  logic        doubleMode = 1'b0;
  logic        syncEnable = 1'b0;
  logic [15:0] targetIn = '0;
  logic [15:0] faultField;
  logic        faultValid;
  logic [15:0] targetOut;

  fault_injector u0 (
    .clk(clk), .rstN(rstN), .rateLimit(rateLimit), .doubleMode(doubleMode),
    .syncEnable(syncEnable), .targetIn(targetIn), .faultField(faultField),
    .faultValid(faultValid), .targetOut(targetOut)
  );

  always #5 clk = ~clk;

  int cycle = 0;
  int checks = 0;
  int failures = 0;
  bit running = 1'b0;
  bit phaseFirst = 1'b1;
  int curRate = 0;
  int lastCycle = 0;
  int collisions = 0;
  logic [15:0] expQ[$];
  logic [15:0] model = 16'hACE1;

  always @(posedge clk) cycle <= cycle + 1;

  function automatic logic [15:0] lfsrStep(logic [15:0] s);
    return {s[14:0], s[15] ^ s[14] ^ s[12] ^ s[3]};
  endfunction

  function automatic logic [15:0] maskOf(logic [15:0] s, bit dbl);
    logic [3:0] a;
    logic [3:0] b;
    logic [15:0] m;
    a = s[3:0];
    b = s[7:4];
    if (b == a) b = a + 4'd1;
    m = 16'd1 << a;
    if (dbl) m = m | (16'd1 << b);
    return m;
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: pops expected masks as strobes appear
  always @(negedge clk) begin
    if (running) begin
      if (faultValid) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R2 unexpected strobe", {16'd0, faultField}, 32'd0);
        end else begin
          logic [15:0] e;
          e = expQ.pop_front();
          check(faultField == e, doubleMode ? "R5 R6 mask" : "R4 R6 mask", {16'd0, faultField}, {16'd0, e});
          check(targetOut == (syncEnable ? (targetIn ^ e) : targetIn), "R8 strobe target",
                {16'd0, targetOut}, {16'd0, syncEnable ? (targetIn ^ e) : targetIn});
          if (!phaseFirst)
            check(cycle - lastCycle == curRate, "R3 spacing", cycle - lastCycle, curRate);
          phaseFirst = 1'b0;
          lastCycle = cycle;
        end
      end else begin
        check(faultField == 16'd0, "R7 idle field", {16'd0, faultField}, 32'd0);
        check(targetOut == targetIn, "R8 idle target", {16'd0, targetOut}, {16'd0, targetIn});
      end
    end
  end

  // Driver: pushes the expected masks of one run, then waits for them
  task automatic runPhase(int rate, bit dbl, bit sync, logic [15:0] tgt, int n);
    @(negedge clk); #1;
    doubleMode = dbl;
    syncEnable = sync;
    targetIn = tgt;
    phaseFirst = 1'b1;
    for (int i = 0; i < n; i++) begin
      if (dbl && model[7:4] == model[3:0]) collisions++;
      expQ.push_back(maskOf(model, dbl));
      model = lfsrStep(model);
    end
    curRate = rate;
    rateLimit = 16'(rate);
    do begin @(negedge clk); #1; end while (expQ.size() != 0);
    rateLimit = '0;
  endtask

  task automatic quietWindow(int len);
    int seen;
    seen = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (faultValid) seen++;
    end
    check(seen == 0, "R2 zero spacing", seen, 0);
  endtask

  always @(posedge clk) begin
    if (cycle > 20000) begin
      failures++;
      $display("FAIL R3 watchdog actual=%0d expected=%0d", cycle, 20000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(faultValid == 1'b0, "R1 reset strobe", faultValid, 0);
    check(faultField == 16'd0, "R1 reset field", faultField, 0);
    #1 rstN = 1'b1;
    @(negedge clk);
    check(faultValid == 1'b0, "R1 post-reset strobe", faultValid, 0);
    check(faultField == 16'd0, "R1 post-reset field", faultField, 0);
    running = 1'b1;
    quietWindow(40);                              // R2
    runPhase(5, 1'b0, 1'b1, 16'h5A3C, 10);        // R4 R3 R8
    runPhase(1, 1'b1, 1'b1, 16'hFFFF, 30);        // R5 R3 back-to-back
    runPhase(199, 1'b0, 1'b0, 16'h1234, 3);       // R3 long spacing, R8 pass-through
    runPhase(2, 1'b1, 1'b0, 16'h0F0F, 60);        // R5 index collisions
    check(collisions > 0, "R5 collision coverage", collisions, 1);
    quietWindow(30);                              // R2
    check(expQ.size() == 0, "R6 all strobes seen", expQ.size(), 0);
    running = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule